// File: doc/BRIEF.md
# Interrupt Level Controller

This block gathers request lines from thirteen interrupt sources and turns them into one 3-bit request level for a processor. Each source owns a byte-wide control register. The register sets the level the source asserts, a 2-bit rank used to choose between sources at the same level, and a flag that selects how the vector is produced. A 16-bit mask register can silence any source. Software reads and writes these registers over a small byte-addressed bus.

When the processor acknowledges a level, the block picks the winning source at that level in the same cycle. The flag in the winner's register then decides the answer. With the flag set, the block returns a vector equal to 24 plus the level. With the flag clear, the block selects the winning peripheral with a one-hot line, and that peripheral supplies its own vector. A source can be pulse-type or line-type. A pulse-type source latches each rising edge of its request line and is released by the acknowledge that selects it. A line-type source simply follows its request line.

Top module: `intc_ctrl`

## Requirements
- R1: After reset the control registers of sources 0 to 6 hold 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C. Source 7 holds 0x1C, sources 8 to 10 hold 0x80 and sources 11 and 12 hold 0x00. Both mask bytes read 0xFF.
- R2: Address n (0 to 12) reads and writes the control register of source n. Its layout is bit 7 = autovector flag, bits 4:2 = level, bits 1:0 = rank, and bits 6:5 always read 0. Address 14 holds mask bits 7:0 and address 15 holds mask bits 15:8. Address 13 reads 0 and ignores writes.
- R3: A source takes part in arbitration only when all of these hold: it is pending, its mask bit (bit n for source n) is 0, and its level is nonzero.
- R4: `ipl_o` equals the highest level among the sources taking part, or 0 when no source takes part.
- R5: On an acknowledge of level L, the winner is the source taking part at level L with the highest rank. A tie in rank goes to the lowest source number.
- R6: When the winner's autovector flag is 1, `iack_vector` is 24+L, `iack_autovec` is 1 and `iack_ext_sel` is 0.
- R7: When the winner's autovector flag is 0, `iack_autovec` is 0, `iack_vector` is 0 and `iack_ext_sel` has exactly the winner's bit set.
- R8: When no source takes part at the acknowledged level, the answer is the spurious vector: `iack_vector` 24, `iack_autovec` 1, `iack_ext_sel` 0.
- R9: Pulse-type sources (8 and 9 by default) become pending on the clock edge after a rising request and stay pending until an acknowledge selects them at a clock edge. Line-type sources are pending exactly while their request is high, and an acknowledge does not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| src_req | input | 13 | Request line per source |
| ipl_o | output | 3 | Level requested from the processor |
| iack_valid | input | 1 | Acknowledge cycle in progress |
| iack_level | input | 3 | Level being acknowledged |
| iack_vector | output | 8 | Vector number returned |
| iack_autovec | output | 1 | Vector comes from this block |
| iack_ext_sel | output | 13 | One-hot select of the peripheral that must supply the vector |

## Verification
The hardest states to reach from the ports are those where a pulse-type source is pending and its request line has already gone quiet, or where it is still held high after being acknowledged. Only the edge latch distinguishes these cases. The bench walks a timer source through raise, acknowledge while held, release and re-raise. A second, higher pulse-type source is stacked on top of it, so that clearing the top source reveals the pending one below. A long pseudo-random sweep rewrites control bytes and mask bytes and applies an acknowledge at every level for each request pattern. This covers the ties in level and rank that decide the winner.

// File: rtl/intc_pkg.sv
// Shared types and reset contents for the interrupt level controller.
// Assumes 8-bit control registers with a fixed field layout.
package intc_pkg;

    localparam int LVL_W  = 3;
    localparam int RANK_W = 2;
    localparam int KEY_W  = LVL_W + RANK_W;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] CTRL_KEEP = 8'h9F;

    // Control byte: vector source flag, two spare bits, level, rank.
    typedef struct packed {
        logic              av;
        logic [1:0]        spare;
        logic [LVL_W-1:0]  lvl;
        logic [RANK_W-1:0] rank;
    } ctrl_t;

    // Reset contents of the control register for source idx.
    function automatic ctrl_t ctrl_reset(input int idx);
        logic [BYTE_W-1:0] v;
        if (idx < 7)       v = 8'((idx + 1) * 4);
        else if (idx == 7) v = 8'h1C;
        else if (idx < 11) v = 8'h80;
        else               v = 8'h00;
        return ctrl_t'(v);
    endfunction

endpackage

// File: rtl/intc_regfile.sv
// Control and mask registers with a byte-addressed access port.
// Assumes NUM_SRC < 2**ADDR_W - 2; the top two addresses hold the mask.
module intc_regfile
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int ADDR_W  = 4,
    parameter int MASK_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BYTE_W-1:0]  wdata,
    output logic [BYTE_W-1:0]  rdata,
    output ctrl_t              ctrl_o [NUM_SRC],
    output logic [NUM_SRC-1:0] mask_o
);
    localparam logic [ADDR_W-1:0] MASK_LO = ADDR_W'((2 ** ADDR_W) - 2);
    localparam logic [ADDR_W-1:0] MASK_HI = ADDR_W'((2 ** ADDR_W) - 1);

    ctrl_t             ctrl_q [NUM_SRC];
    logic [MASK_W-1:0] mask_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_ctrl
        // Hold one control byte; spare bits are forced to zero.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctrl_q[g] <= ctrl_reset(g);
            else if (wr_en && addr == ADDR_W'(g))
                ctrl_q[g] <= ctrl_t'(wdata & CTRL_KEEP);
        end
        assign ctrl_o[g] = ctrl_q[g];
    end

    // Hold the mask, written one byte at a time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (wr_en && addr == MASK_LO)
            mask_q[7:0] <= wdata;
        else if (wr_en && addr == MASK_HI)
            mask_q[15:8] <= wdata;
    end

    assign mask_o = mask_q[NUM_SRC-1:0];

    // Return the byte selected by addr.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_SRC; i++)
            if (addr == ADDR_W'(i)) rdata = ctrl_q[i];
        if (addr == MASK_LO) rdata = mask_q[7:0];
        if (addr == MASK_HI) rdata = mask_q[15:8];
    end

    // R2: spare bits of a control byte never read back as one.
    a_r2_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr) < NUM_SRC) |-> (rdata[6:5] == 2'b00));

endmodule

// File: rtl/intc_pending.sv
// Pending state per source: pulse-type sources latch rising edges and
// are released by clr; line-type sources follow their request.
// Assumes clr is one-hot and only names a pending source.
module intc_pending #(
    parameter int                 NUM_SRC  = 13,
    parameter logic [NUM_SRC-1:0] EDGE_SRC = 'h0300
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] pend
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (EDGE_SRC[g]) begin : g_edge
            logic req_d;
            logic hold;
            // Latch a rising edge; release on acknowledge.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    req_d <= 1'b0;
                    hold  <= 1'b0;
                end else begin
                    req_d <= req[g];
                    hold  <= (hold & ~clr[g]) | (req[g] & ~req_d);
                end
            end
            assign pend[g] = hold;

            // R9: an acknowledge without a fresh edge leaves it idle.
            a_r9_edge_release: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[g] && !(req[g] && !req_d)) |=> !pend[g]);
            // R9: a rising request is pending on the next cycle.
            a_r9_edge_catch: assert property (@(posedge clk) disable iff (!rst_n)
                (req[g] && !req_d) |=> pend[g]);
        end else begin : g_line
            assign pend[g] = req[g];

            // R9: a line-type source is only acknowledged while requesting.
            a_r9_line_clr_has_req: assert property (@(posedge clk) disable iff (!rst_n)
                clr[g] |-> req[g]);
        end
    end

endmodule

// File: rtl/intc_arbiter.sv
// Picks the candidate with the largest key; ties go to the lowest index.
// Purely combinational; clk and rst_n serve the assertions only.
module intc_arbiter #(
    parameter int NUM_SRC = 13,
    parameter int KEY_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] cand,
    input  logic [KEY_W-1:0]   key [NUM_SRC],
    output logic               found,
    output logic [NUM_SRC-1:0] win_onehot,
    output logic [KEY_W-1:0]   win_key
);
    localparam int IDX_W = $clog2(NUM_SRC);

    logic [IDX_W-1:0] win_idx;

    // Linear scan; strict compare keeps the earliest of equal keys.
    always_comb begin
        found   = 1'b0;
        win_key = '0;
        win_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cand[i] && (!found || key[i] > win_key)) begin
                found   = 1'b1;
                win_key = key[i];
                win_idx = IDX_W'(i);
            end
        end
        win_onehot = found ? (NUM_SRC'(1) << win_idx) : '0;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        // R5: no candidate outranks the winner.
        a_r5_winner_max: assert property (@(posedge clk) disable iff (!rst_n)
            cand[g] |-> (found && win_key >= key[g]));
        // R5: equal keys resolve to the lowest index.
        a_r5_tie_low: assert property (@(posedge clk) disable iff (!rst_n)
            (cand[g] && key[g] == win_key) |-> (int'(win_idx) <= g));
    end

endmodule

// File: rtl/intc_ctrl.sv
// Interrupt level controller top: registers, pending state, level
// arbitration and same-cycle acknowledge answer.
// Assumes the processor holds iack_level steady while iack_valid is high.
module intc_ctrl
    import intc_pkg::*;
#(
    parameter int                 NUM_SRC  = 13,
    parameter int                 ADDR_W   = 4,
    parameter logic [NUM_SRC-1:0] EDGE_SRC = 'h0300,
    parameter logic [7:0]         AV_BASE  = 8'd24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic [NUM_SRC-1:0] src_req,
    output logic [2:0]         ipl_o,
    input  logic               iack_valid,
    input  logic [2:0]         iack_level,
    output logic [7:0]         iack_vector,
    output logic               iack_autovec,
    output logic [NUM_SRC-1:0] iack_ext_sel
);
    ctrl_t              ctrl [NUM_SRC];
    logic [NUM_SRC-1:0] mask;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] live;
    logic [NUM_SRC-1:0] at_lvl;
    logic [NUM_SRC-1:0] av_vec;
    logic [KEY_W-1:0]   key [NUM_SRC];

    logic               top_found;
    logic [NUM_SRC-1:0] top_onehot;
    logic [KEY_W-1:0]   top_key;
    logic               ack_found;
    logic [NUM_SRC-1:0] ack_onehot;
    logic [KEY_W-1:0]   ack_key;

    intc_regfile #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .ctrl_o(ctrl), .mask_o(mask)
    );

    intc_pending #(.NUM_SRC(NUM_SRC), .EDGE_SRC(EDGE_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .req(src_req), .clr(clr), .pend(pend)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign live[g]   = pend[g] & ~mask[g] & (ctrl[g].lvl != '0);
        assign at_lvl[g] = live[g] & (ctrl[g].lvl == iack_level);
        assign key[g]    = {ctrl[g].lvl, ctrl[g].rank};
        assign av_vec[g] = ctrl[g].av;
    end

    intc_arbiter #(.NUM_SRC(NUM_SRC), .KEY_W(KEY_W)) u_top_arb (
        .clk(clk), .rst_n(rst_n), .cand(live), .key(key),
        .found(top_found), .win_onehot(top_onehot), .win_key(top_key)
    );

    intc_arbiter #(.NUM_SRC(NUM_SRC), .KEY_W(KEY_W)) u_ack_arb (
        .clk(clk), .rst_n(rst_n), .cand(at_lvl), .key(key),
        .found(ack_found), .win_onehot(ack_onehot), .win_key(ack_key)
    );

    assign ipl_o = top_found ? top_key[KEY_W-1:RANK_W] : '0;

    // Form the acknowledge answer and the release of the winner.
    always_comb begin
        iack_vector  = '0;
        iack_autovec = 1'b0;
        iack_ext_sel = '0;
        clr          = '0;
        if (iack_valid) begin
            if (!ack_found) begin
                iack_vector  = AV_BASE;
                iack_autovec = 1'b1;
            end else begin
                clr = ack_onehot;
                if (|(ack_onehot & av_vec)) begin
                    iack_vector  = AV_BASE + 8'(iack_level);
                    iack_autovec = 1'b1;
                end else begin
                    iack_ext_sel = ack_onehot;
                end
            end
        end
    end

    // R4: a nonzero level always has exactly one source behind it.
    a_r4_level_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (ipl_o != 3'd0) |-> $onehot(top_onehot));
    // R4: an acknowledged source never sits above the requested level.
    a_r4_ack_below_ipl: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_valid && ack_found) |-> (ipl_o >= iack_level));
    // R5: the acknowledge winner sits at the acknowledged level.
    a_r5_ack_level: assert property (@(posedge clk) disable iff (!rst_n)
        ack_found |-> (ack_key[KEY_W-1:RANK_W] == iack_level));
    // R7: at most one peripheral is told to supply a vector.
    a_r7_ext_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(iack_ext_sel));
    // R7: a peripheral select never comes with an internal vector.
    a_r7_ext_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (|iack_ext_sel) |-> (!iack_autovec && iack_vector == 8'd0));

endmodule

// File: tb/intc_ctrl_tb.sv
// Self-checking bench for intc_ctrl: reset map, register access,
// pseudo-random sweep with a reference model, pulse-type sequences.
module intc_ctrl_tb;
    localparam int N = 13;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [7:0]   reg_wdata = '0;
    logic [7:0]   reg_rdata;
    logic [N-1:0] src_req = '0;
    logic [2:0]   ipl_o;
    logic         iack_valid = 1'b0;
    logic [2:0]   iack_level = '0;
    logic [7:0]   iack_vector;
    logic         iack_autovec;
    logic [N-1:0] iack_ext_sel;

    int vecs = 0;
    int fails = 0;
    logic [7:0]   m_ctrl [N];
    logic [15:0]  m_mask;
    logic [N-1:0] m_pend;
    logic [31:0]  lf = 32'h1ACE_5EED;

    always #10 clk = ~clk;

    intc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req),
        .ipl_o(ipl_o), .iack_valid(iack_valid), .iack_level(iack_level),
        .iack_vector(iack_vector), .iack_autovec(iack_autovec),
        .iack_ext_sel(iack_ext_sel)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a < 4'(N)) m_ctrl[a] = d & 8'h9F;
        if (a == 4'd14) m_mask[7:0] = d;
        if (a == 4'd15) m_mask[15:8] = d;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(tag, 32'(reg_rdata), 32'(exp));
    endtask

    // Reference winner among live sources; lv < 0 means any level.
    function automatic int pick(input int lv);
        int best = -1;
        logic [4:0] bk = '0;
        for (int i = 0; i < N; i++) begin
            if (m_pend[i] && !m_mask[i] && m_ctrl[i][4:2] != 3'd0 &&
                (lv < 0 || int'(m_ctrl[i][4:2]) == lv)) begin
                if (best < 0 || m_ctrl[i][4:0] > bk) begin
                    best = i; bk = m_ctrl[i][4:0];
                end
            end
        end
        return best;
    endfunction

    task automatic ipl_chk(input string tag);
        int w;
        #1;
        w = pick(-1);
        chk(tag, 32'(ipl_o), (w < 0) ? 32'd0 : 32'(m_ctrl[w][4:2]));
    endtask

    // Acknowledge level lv combinationally and compare all three outputs.
    task automatic ack_chk(input int lv, input string tag);
        int w;
        iack_valid = 1'b1; iack_level = 3'(lv);
        #1;
        w = pick(lv);
        if (w < 0) begin
            chk({tag, " R8 vec"}, 32'(iack_vector), 32'd24);
            chk({tag, " R8 av"}, 32'(iack_autovec), 32'd1);
            chk({tag, " R8 sel"}, 32'(iack_ext_sel), 32'd0);
        end else if (m_ctrl[w][7]) begin
            chk({tag, " R6 vec"}, 32'(iack_vector), 32'(24 + lv));
            chk({tag, " R6 av"}, 32'(iack_autovec), 32'd1);
            chk({tag, " R6 R5 sel"}, 32'(iack_ext_sel), 32'd0);
        end else begin
            chk({tag, " R7 vec"}, 32'(iack_vector), 32'd0);
            chk({tag, " R7 av"}, 32'(iack_autovec), 32'd0);
            chk({tag, " R7 R5 sel"}, 32'(iack_ext_sel), 32'(1 << w));
        end
    endtask

    task automatic step_lf();
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++)
            m_ctrl[i] = (i < 7) ? 8'((i + 1) * 4) : (i == 7) ? 8'h1C : (i < 11) ? 8'h80 : 8'h00;
        m_mask = 16'hFFFF;
        m_pend = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents of every address
        for (int a = 0; a < 16; a++) begin
            logic [7:0] e;
            e = (a < N) ? m_ctrl[a] : (a == 13) ? 8'h00 : 8'hFF;
            rd_chk(4'(a), e, "R1 reset value");
        end
        ipl_chk("R1 R4 idle level");

        // R2: spare bits, unused address, mask bytes
        wr(4'd3, 8'hFF);
        rd_chk(4'd3, 8'h9F, "R2 spare bits zero");
        wr(4'd13, 8'h5A);
        rd_chk(4'd13, 8'h00, "R2 unused address");
        wr(4'd14, 8'h00);
        wr(4'd15, 8'h00);
        rd_chk(4'd14, 8'h00, "R2 mask low");
        rd_chk(4'd15, 8'h00, "R2 mask high");

        // R3: mask bit and zero level remove a requesting source
        wr(4'd0, 8'h18);
        src_req = 13'h0001; m_pend = 13'h0001;
        ipl_chk("R3 R4 unmasked source");
        wr(4'd14, 8'h01);
        ipl_chk("R3 masked source");
        chk("R3 masked level", 32'(ipl_o), 32'd0);
        wr(4'd14, 8'h00);
        wr(4'd0, 8'h80);
        chk("R3 zero level", 32'(ipl_o), 32'd0);

        // R5: rank beats index, then lowest index on equal rank
        wr(4'd2, 8'h0D);
        wr(4'd5, 8'h0E);
        wr(4'd6, 8'h0E);
        src_req = 13'h0064; m_pend = 13'h0064;
        @(negedge clk);
        ack_chk(3, "R5 rank then index");
        chk("R5 winner", 32'(iack_ext_sel), 32'(1 << 5));
        iack_valid = 1'b0;

        // Sweep: random control bytes, masks and line-type requests
        for (int it = 0; it < 400; it++) begin
            step_lf();
            wr(4'(lf[7:0] % N), lf[15:8]);
            if (it % 4 == 0) begin
                step_lf();
                wr(4'd14, lf[7:0] & lf[15:8]);
                wr(4'd15, lf[23:16]);
            end
            step_lf();
            src_req = lf[12:0] & ~13'h0300;
            m_pend = src_req;
            ipl_chk("R4 sweep level");
            for (int lv = 0; lv < 8; lv++) ack_chk(lv, "sweep ack");
            iack_valid = 1'b0;
        end

        // R9: pulse-type sources 8 and 9
        src_req = '0; m_pend = '0;
        wr(4'd14, 8'h00);
        wr(4'd15, 8'h00);
        for (int i = 0; i < N; i++) if (i != 8 && i != 9) wr(4'(i), 8'h00);
        wr(4'd8, 8'h94);
        src_req[8] = 1'b1;
        #1;
        chk("R9 edge not yet visible", 32'(ipl_o), 32'd0);
        @(negedge clk);
        m_pend[8] = 1'b1;
        ipl_chk("R9 edge latched");
        ack_chk(5, "R9 edge ack");
        @(negedge clk);
        iack_valid = 1'b0;
        m_pend[8] = 1'b0;
        #1;
        chk("R9 released while held high", 32'(ipl_o), 32'd0);
        src_req[8] = 1'b0;
        @(negedge clk);
        chk("R9 idle after drop", 32'(ipl_o), 32'd0);
        src_req[8] = 1'b1;
        @(negedge clk);
        m_pend[8] = 1'b1;
        ipl_chk("R9 second edge");
        wr(4'd9, 8'h1E);
        src_req[9] = 1'b1;
        @(negedge clk);
        m_pend[9] = 1'b1;
        ipl_chk("R9 higher pulse source");
        ack_chk(7, "R9 vendor vector");
        @(negedge clk);
        iack_valid = 1'b0;
        m_pend[9] = 1'b0;
        #1;
        chk("R9 lower source revealed", 32'(ipl_o), 32'd5);

        // R9: acknowledge leaves a line-type source pending
        wr(4'd1, 8'h1C);
        src_req[1] = 1'b1; m_pend[1] = 1'b1;
        ack_chk(7, "R9 line ack");
        @(negedge clk);
        iack_valid = 1'b0;
        #1;
        chk("R9 line source kept", 32'(ipl_o), 32'd7);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule